// File: doc/BRIEF.md
# Programmable Serial Audio Frame Timing Engine

This block produces, or follows, the frame structure of a serial audio link one bit clock at a time. Everything runs on a single system clock. Bit clock edges are events inside that clock domain. As a clock master the block toggles its own bit clock output on each `half_tick` pulse from an external divider. As a clock slave it watches an already synchronised `bclk_i` input. The edge treated as active, rising or falling, is selectable.

As a sync master the block drives `fs_o`, holding it active for a programmable number of bit clocks at the start of each frame. As a sync slave it finds the frame start in the sampled `fs_i` input. Frame length, sync pulse width, sync polarity, active edge and both mastership choices are run-time inputs. One engine therefore covers two-channel I2S (50% duty, inverted start), the justified formats and short-pulse DSP framing.

The downstream channel logic receives three things on every active bit clock edge: a bit position counter, a bit strobe and a frame-start strobe. After standby is released, a warm-up of four active edges has to pass before any frame begins.

Top module: `pcm_frame_timer`

## Requirements
- R1: After reset, and while `en` or `stby_off` is low, the outputs sit idle: `bit_tick` = 0, `frame_start` = 0, `bit_pos` = 0, `bclk_o` = 0, and `fs_o` equals `fs_inv`, which is the inactive sync level.
- R2: Once both `en` and `stby_off` are high, the first four active bit clock edges give no `bit_tick` and no frame start. In sync master mode the fifth active edge is the first frame start.
- R3: In sync master mode, every active edge from then on gives one `bit_tick`. `bit_pos` runs 0, 1, … up to `frame_len_m1` and wraps to 0. `frame_start` is 1 exactly on the edges where `bit_pos` is 0. The frame length is `frame_len_m1` + 1, from 1 to 1024.
- R4: In sync master mode, `fs_o` is at its active level (`~fs_inv`) while `bit_pos` < `sync_len`, and at `fs_inv` otherwise. With `fs_inv` = 1 the frame therefore starts on a falling edge of `fs_o`.
- R5: In clock master mode (`clk_slave` = 0) and while running, `bclk_o` starts at 0 and toggles on every `half_tick`. The active edge is rising when `clk_norm` = 1 and falling when `clk_norm` = 0.
- R6: In clock slave mode the active edges are taken from `bclk_i`: a change to 1 when `clk_norm` = 1, or a change to 0 when `clk_norm` = 0. `half_tick` is ignored and `bclk_o` stays 0.
- R7: In sync slave mode, `fs_i` XOR `fs_inv` is sampled on each active edge. A frame starts on an active edge where this value is 1 and was 0 on the previous active edge. At that point `bit_pos` restarts at 0, even in the middle of a frame. Right after enabling, the previous value counts as 1. No `bit_tick` appears before the first detected start, and `fs_o` holds `fs_inv`.
- R8: In sync slave mode, when no new sync edge arrives, `bit_pos` wraps from `frame_len_m1` to 0 with `frame_start` = 0.
- R9: `bit_tick` and `frame_start` are single system clock pulses. They appear in the cycle after the one in which the active edge is seen (the `half_tick` cycle, or the first cycle `bclk_i` shows its new level).
- R10: Dropping `en` mid-frame returns the outputs to the R1 idle state. Re-enabling requires the full R2 warm-up again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable |
| stby_off | input | 1 | 1 releases standby |
| frame_len_m1 | input | 10 | Frame length minus one, in bit clocks |
| sync_len | input | 10 | Sync active width in bit clocks (sync master) |
| clk_slave | input | 1 | 1 takes bit clock from `bclk_i` |
| fs_slave | input | 1 | 1 takes frame sync from `fs_i` |
| clk_norm | input | 1 | 1: active edge is rising; 0: falling |
| fs_inv | input | 1 | 1: frame starts on falling sync edge |
| half_tick | input | 1 | Half-period pulse for the master bit clock |
| bclk_i | input | 1 | External bit clock, synchronised |
| fs_i | input | 1 | External frame sync, synchronised |
| bclk_o | output | 1 | Generated bit clock |
| fs_o | output | 1 | Generated frame sync |
| bit_pos | output | 10 | Position of the current bit in its frame |
| bit_tick | output | 1 | One pulse per active bit clock edge |
| frame_start | output | 1 | One pulse at bit position 0 |

## Verification
Two things can land on the same active edge in sync slave mode: the counter's own wrap at the end of the frame and an externally detected frame start. The bench drives random sync patterns whose period is shorter than, equal to or longer than the programmed frame. This makes the external edge arrive before, exactly on, or after the wrap point. On every such edge the bench predicts the position and the start strobe from its own model. A coinciding edge must give position 0 with a single `frame_start` pulse. An early edge must restart the count. A late edge must give a wrap with no strobe.

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer #(
  parameter int LEN_W      = 10,
  parameter int WARM_EDGES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             stby_off,
  input  logic [LEN_W-1:0] frame_len_m1,
  input  logic [LEN_W-1:0] sync_len,
  input  logic             clk_slave,
  input  logic             fs_slave,
  input  logic             clk_norm,
  input  logic             fs_inv,
  input  logic             half_tick,
  input  logic             bclk_i,
  input  logic             fs_i,
  output logic             bclk_o,
  output logic             fs_o,
  output logic [LEN_W-1:0] bit_pos,
  output logic             bit_tick,
  output logic             frame_start
);
  localparam int WW = $clog2(WARM_EDGES + 1);

  logic             run;
  logic             bclk_q, bclk_d;
  logic             fsn_prev, primed;
  logic [WW-1:0]    warm;
  logic [LEN_W-1:0] pos_q, pos_nxt;
  logic             fs_q, tick_q, start_q;
  logic             edge_m, edge_s, act, ready;
  logic             fsn, ext_start, last, go_start, advance;

  assign run       = en & stby_off;
  assign edge_m    = run & half_tick & (bclk_q != clk_norm);
  assign edge_s    = run & (bclk_i != bclk_d) & (bclk_i == clk_norm);
  assign act       = clk_slave ? edge_s : edge_m;
  assign ready     = (warm == WW'(WARM_EDGES));
  assign fsn       = fs_i ^ fs_inv;
  assign ext_start = fsn & ~fsn_prev;
  assign last      = (pos_q == frame_len_m1);
  assign go_start  = fs_slave ? ext_start : (~primed | last);
  assign pos_nxt   = (go_start | last) ? '0 : pos_q + LEN_W'(1);
  assign advance   = act & ready & (fs_slave ? (primed | ext_start) : 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q   <= 1'b0;
      bclk_d   <= 1'b0;
      fsn_prev <= 1'b1;
      primed   <= 1'b0;
      warm     <= '0;
      pos_q    <= '0;
      fs_q     <= 1'b0;
      tick_q   <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      bclk_d  <= bclk_i;
      tick_q  <= 1'b0;
      start_q <= 1'b0;
      if (!run) begin
        bclk_q   <= 1'b0;
        fsn_prev <= 1'b1;
        primed   <= 1'b0;
        warm     <= '0;
        pos_q    <= '0;
        fs_q     <= fs_inv;
      end else begin
        if (half_tick && !clk_slave) bclk_q <= ~bclk_q;
        if (act) fsn_prev <= fsn;
        if (act && !ready) warm <= warm + WW'(1);
        if (advance) begin
          primed  <= 1'b1;
          pos_q   <= pos_nxt;
          tick_q  <= 1'b1;
          start_q <= go_start;
          fs_q    <= fs_inv ^ (~fs_slave & (pos_nxt < sync_len));
        end else if (!primed) begin
          fs_q <= fs_inv;
        end
      end
    end
  end

  assign bclk_o      = bclk_q;
  assign fs_o        = fs_q;
  assign bit_pos     = pos_q;
  assign bit_tick    = tick_q;
  assign frame_start = start_q;

  assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!bit_tick && !frame_start && bit_pos == '0));

  assert_no_early_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> ready);

  assert_start_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (bit_tick && bit_pos == '0));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);

  assert_bclk_toggles_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clk_slave && half_tick) |=> (bclk_o != $past(bclk_o)));

  assert_bclk_quiet_slave_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_slave && $past(clk_slave) && !$past(bclk_o)) |-> !bclk_o);

  assert_fs_active_at_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !fs_slave && $stable(sync_len) && $stable(fs_inv) && sync_len != '0)
      |-> (fs_o == ~fs_inv));
endmodule

// File: tb/pcm_frame_timer_bench.sv
`timescale 1ns/1ps
module pcm_frame_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, stby_off = 1'b0;
  logic [9:0] frame_len_m1 = '0, sync_len = '0;
  logic       clk_slave = 1'b0, fs_slave = 1'b0, clk_norm = 1'b1, fs_inv = 1'b0;
  logic       half_tick = 1'b0, bclk_i = 1'b0, fs_i = 1'b0;
  logic       bclk_o, fs_o, bit_tick, frame_start;
  logic [9:0] bit_pos;

  int errors = 0, checks = 0;
  int m_edges, m_pos, m_synced, m_prev, m_fs, lvl, prev_act;

  always #2.5 clk = ~clk;

  pcm_frame_timer u_pcm_frame_timer (
    .clk(clk), .rst_n(rst_n), .en(en), .stby_off(stby_off),
    .frame_len_m1(frame_len_m1), .sync_len(sync_len),
    .clk_slave(clk_slave), .fs_slave(fs_slave), .clk_norm(clk_norm), .fs_inv(fs_inv),
    .half_tick(half_tick), .bclk_i(bclk_i), .fs_i(fs_i),
    .bclk_o(bclk_o), .fs_o(fs_o), .bit_pos(bit_pos),
    .bit_tick(bit_tick), .frame_start(frame_start));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic idle_check(input string req);
    chk(req, "bit_tick idle", int'(bit_tick), 0);
    chk(req, "frame_start idle", int'(frame_start), 0);
    chk(req, "bit_pos idle", int'(bit_pos), 0);
    chk(req, "bclk_o idle", int'(bclk_o), 0);
    chk(req, "fs_o idle", int'(fs_o), int'(fs_inv));
  endtask

  task automatic start_run();
    @(negedge clk);
    en = 1'b1; stby_off = 1'b1;
    m_edges = 0; m_pos = 0; m_synced = 0; m_prev = 1; m_fs = int'(fs_inv);
    lvl = clk_slave ? int'(bclk_i) : 0;
    prev_act = 0;
  endtask

  task automatic stop_run();
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    prev_act = 0;
  endtask

  task automatic half(input logic fsv);
    int act, L, tick_e, start_e, fsn, st;
    @(negedge clk);
    if (prev_act != 0) chk("R9", "strobe width", int'(bit_tick), 0);
    fs_i = fsv;
    if (clk_slave) begin
      bclk_i = ~bclk_i;
      lvl = int'(bclk_i);
    end else begin
      half_tick = 1'b1;
      if (en && stby_off) lvl = 1 - lvl;
    end
    act = (en && stby_off && lvl == int'(clk_norm)) ? 1 : 0;
    @(negedge clk);
    half_tick = 1'b0;
    if (clk_slave) chk("R6", "bclk_o held", int'(bclk_o), 0);
    else           chk("R5", "bclk_o level", int'(bclk_o), lvl);
    tick_e = 0; start_e = 0;
    L = int'(frame_len_m1) + 1;
    if (act != 0) begin
      m_edges++;
      fsn = int'(fsv ^ fs_inv);
      if (m_edges <= 4) begin
        m_prev = fsn;
      end else if (!fs_slave) begin
        if (m_synced == 0 || m_pos == L - 1) m_pos = 0; else m_pos++;
        m_synced = 1; tick_e = 1; start_e = (m_pos == 0) ? 1 : 0;
        m_fs = int'(fs_inv) ^ ((m_pos < int'(sync_len)) ? 1 : 0);
      end else begin
        st = fsn & (1 - m_prev);
        if (st != 0) begin
          m_pos = 0; m_synced = 1; tick_e = 1; start_e = 1;
        end else if (m_synced != 0) begin
          m_pos = (m_pos == L - 1) ? 0 : m_pos + 1; tick_e = 1;
        end
        m_prev = fsn;
        m_fs = int'(fs_inv);
      end
    end
    if (m_edges <= 4) chk("R2", "bit_tick", int'(bit_tick), tick_e);
    else if (fs_slave) chk("R7", "bit_tick", int'(bit_tick), tick_e);
    else chk("R3", "bit_tick", int'(bit_tick), tick_e);
    if (fs_slave) begin
      chk("R7", "frame_start", int'(frame_start), start_e);
      if (tick_e != 0) chk("R8", "bit_pos", int'(bit_pos), m_pos);
      chk("R7", "fs_o held", int'(fs_o), m_fs);
    end else begin
      chk("R3", "frame_start", int'(frame_start), start_e);
      if (tick_e != 0) chk("R3", "bit_pos", int'(bit_pos), m_pos);
      chk("R4", "fs_o", int'(fs_o), m_fs);
    end
    prev_act = act;
  endtask

  task automatic one_bit(input logic fsv);
    half(fsv);
    half(fsv);
  endtask

  task automatic master_run(input int len, input int sl, input logic cn, input logic fi,
                            input logic cs, input int nbits);
    frame_len_m1 = 10'(len - 1); sync_len = 10'(sl);
    clk_norm = cn; fs_inv = fi; clk_slave = cs; fs_slave = 1'b0;
    start_run();
    for (int k = 0; k < nbits; k++) one_bit(1'b0);
    stop_run();
    idle_check("R10");
  endtask

  task automatic slave_run(input int len, input int period, input int width,
                           input logic cn, input logic fi, input logic cs, input int nbits);
    frame_len_m1 = 10'(len - 1); sync_len = 10'(1);
    clk_norm = cn; fs_inv = fi; clk_slave = cs; fs_slave = 1'b1;
    start_run();
    for (int k = 0; k < nbits; k++)
      one_bit(fi ^ (((k % period) < width) ? 1'b1 : 1'b0));
    stop_run();
    idle_check("R10");
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int L, P, W;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    idle_check("R1");

    // R1: standby held while enabled, half ticks must have no effect
    en = 1'b1; stby_off = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); half_tick = 1'b1;
      @(negedge clk); half_tick = 1'b0;
      idle_check("R1");
    end
    en = 1'b0;
    @(negedge clk);

    // R2 R3 R4 R5: directed I2S-like master frame
    master_run(8, 4, 1'b1, 1'b1, 1'b0, 30);
    // single-bit frame, DSP pulse, falling active edge
    master_run(1, 1, 1'b0, 1'b0, 1'b0, 10);
    // zero sync width: fs never active
    master_run(5, 0, 1'b1, 1'b0, 1'b0, 16);
    // sync master with clock slave, R6
    master_run(6, 1, 1'b0, 1'b0, 1'b1, 20);

    // R6: half_tick ignored in clock slave mode
    clk_slave = 1'b1; fs_slave = 1'b0; frame_len_m1 = 10'd3;
    start_run();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); half_tick = 1'b1;
      @(negedge clk); half_tick = 1'b0;
      chk("R6", "bclk_o ignores half_tick", int'(bclk_o), 0);
      chk("R6", "no tick from half_tick", int'(bit_tick), 0);
    end
    stop_run();

    // R3: longest frame, wrap at 1023
    master_run(1024, 512, 1'b1, 1'b0, 1'b0, 4 + 1024 + 3);

    // R7: sync period shorter than frame restarts mid-frame
    slave_run(6, 4, 1, 1'b1, 1'b0, 1'b1, 24);
    // R8: sync period longer than frame wraps silently
    slave_run(6, 10, 5, 1'b0, 1'b1, 1'b1, 36);
    // coinciding external start and own wrap
    slave_run(8, 8, 4, 1'b1, 1'b1, 1'b0, 36);

    // R10: disable mid-frame then re-enable needs warm-up again
    frame_len_m1 = 10'd9; sync_len = 10'd5; clk_slave = 1'b0; fs_slave = 1'b0;
    clk_norm = 1'b1; fs_inv = 1'b0;
    start_run();
    for (int k = 0; k < 8; k++) one_bit(1'b0);
    stop_run();
    idle_check("R10");
    start_run();
    for (int k = 0; k < 8; k++) one_bit(1'b0);
    stop_run();

    // random mix of configurations
    for (int it = 0; it < 14; it++) begin
      L = $urandom_range(1, 24);
      if ($urandom_range(0, 1) == 0) begin
        master_run(L, $urandom_range(0, L), 1'($urandom_range(0, 1)),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 4 + 3 * L + 2);
      end else begin
        P = $urandom_range((L > 4) ? L - 3 : 2, L + 3);
        W = (P / 2 > 0) ? P / 2 : 1;
        slave_run(L, P, W, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)), 4 + 4 * P + 2);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule